// File: doc/BRIEF.md
# Pulse-and-Verify EPROM Programming Sequencer

This controller writes a contiguous range of byte locations into an erasable PROM. It burns each byte with a series of short program pulses rather than one long pulse. Software or a host engine gives a first and a last address and strobes `start`. For each address the sequencer asks a source-data port for the wanted byte, using a request/valid handshake. A wanted value of all ones needs no work, because an erased cell already holds ones. For any other value the sequencer first reads the location back (the blank check). A location that holds a 0 where a 1 is wanted cannot be repaired, so the run ends at once.

When programming is needed, the sequencer drives address and data onto the device and holds them through a setup interval. It then lowers the chip-enable/program line for a fixed pulse whose length comes from the clock frequency. After each pulse it floats the data bus and does a verify read with chip enable and output enable both low, sampling the bus a set number of cycles after chip enable falls. Pulses repeat at the same address until the byte reads back correctly or the pulse limit is reached. Reaching the limit stops the run with `fail` and the failing address. A run that completes raises `done` for one cycle. A per-address pulse count and a run total stay readable afterwards. The block only requests the programming supply through `vpp_en`; producing the high voltage is left to the board.

Top module: `eprog_sequencer`

## Requirements
- R1: `vpp_en` is high in every cycle of a run (`busy` high) and low when idle. Whenever `rom_ce_pgm_n` is low with `rom_oe_n` high (a program pulse), `vpp_en` and `rom_dout_en` are both high.
- R2: Every program pulse lasts exactly PULSE_CYC = (CLK_HZ/1000)·PULSE_US/1000 cycles. It is preceded by SETUP_CYC cycles in which address and data are already driven. Address and data stay unchanged during the pulse. `rom_ce_pgm_n` returns high before any read begins.
- R3: A verify or blank-check read holds `rom_ce_pgm_n` and `rom_oe_n` low with the data bus floated. `rom_din` is sampled in the TDV_CYC-th cycle after chip enable falls.
- R4: At one address, pulse-and-verify repeats until the read-back equals the target byte, with at most MAX_PULSES pulses.
- R5: If the byte still differs after MAX_PULSES pulses, the run stops: `busy` drops, `fail` goes high and `fail_addr` holds that address. `fail` stays high until the next `start`.
- R6: `rom_dout_en` is never high while `rom_oe_n` is low. At least one cycle with the bus floated and `rom_oe_n` high separates any read from any driven phase.
- R7: A target byte of 8'hFF is skipped without a read or a pulse, and that location is left untouched.
- R8: The blank-check read fails the run at once, with no pulse, if the stored byte has a 0 in any bit where the target has a 1.
- R9: If the blank-check read already equals the target, the address gets no pulse.
- R10: Addresses are handled in ascending order from `start_addr` to `end_addr` inclusive. After the last one, `done` is high for exactly one cycle and `busy` then drops.
- R11: `addr_pulses` counts the pulses given to the current (last handled) address and is cleared when its byte is fetched. `total_pulses` counts all pulses of the run and is cleared by `start`. Both hold their values after the run ends.
- R12: `src_req` stays high with `src_addr` equal to the address being handled until `src_valid` is seen. One fetch is made per address visited.
- R13: After reset the block is idle: `busy`, `done`, `fail` and `vpp_en` are low, `rom_ce_pgm_n` and `rom_oe_n` are high, the bus is floated, and both counters are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start | input | 1 | Begin a run (taken only when idle) |
| start_addr | input | AW | First address of the range |
| end_addr | input | AW | Last address of the range (inclusive) |
| busy | output | 1 | A run is in progress |
| done | output | 1 | One-cycle completion pulse |
| fail | output | 1 | Run stopped on an unprogrammable byte |
| fail_addr | output | AW | Address that failed |
| addr_pulses | output | PCW | Pulses given to the current address |
| total_pulses | output | TOT_W | Pulses given in the whole run |
| src_req | output | 1 | Request for the target byte |
| src_addr | output | AW | Address of the requested byte |
| src_valid | input | 1 | Source byte present on `src_data` |
| src_data | input | DW | Target byte |
| rom_addr | output | AW | Device address |
| rom_dout | output | DW | Data driven to the device |
| rom_dout_en | output | 1 | Drive enable for `rom_dout` |
| rom_din | input | DW | Data read from the device |
| rom_ce_pgm_n | output | 1 | Active-low chip enable / program pulse |
| rom_oe_n | output | 1 | Active-low output enable |
| vpp_en | output | 1 | Request for the programming supply |

## Verification
The hardest case to reach is an address that needs exactly the pulse limit, next to one that needs one pulse more. A device that obeys every pulse cannot produce it. The bench therefore uses a device model in which each location needs a set number of pulses before its cells take the data. Setting that number to 10 and to 11 places the sequencer on both sides of the limit. The same model returns the inverted byte when a read is sampled before the access delay has passed, so early sampling shows up as a wrong result. Preloaded contents drive the blank-check outcomes: a 0 stored where a 1 is wanted, and a byte that already matches.

// File: rtl/eprog_pkg.sv
// Package: shared types of the EPROM programming sequencer.
// Assumes: nothing beyond IEEE 1800-2017.
package eprog_pkg;

    // Sequencer phases; order carries no meaning.
    typedef enum logic [3:0] {
        ST_IDLE,
        ST_FETCH,
        ST_BLANK,
        ST_TURN,
        ST_SETUP,
        ST_PULSE,
        ST_RECOV,
        ST_VERIFY,
        ST_NEXT,
        ST_DONE,
        ST_FAIL
    } seq_state_t;

endpackage

// File: rtl/eprog_phase_timer.sv
// Module: down-counting phase timer. A load sets the remaining count to
// load_val; the count then falls by one per cycle and stops at zero.
// Assumes: the owner loads (length - 1) on entry to a timed phase and
// leaves the phase in the cycle where expired is high.
module eprog_phase_timer #(
    parameter int CW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          load,
    input  logic [CW-1:0] load_val,
    output logic          expired
);

    logic [CW-1:0] cnt;

    // Count register: load, or step down to zero.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt <= '0;
        end else if (load) begin
            cnt <= load_val;
        end else if (cnt != '0) begin
            cnt <= cnt - 1'b1;
        end
    end

    // Phase ends in the cycle the count reads zero.
    assign expired = (cnt == '0);

endmodule

// File: rtl/eprog_byte_cmp.sv
// Module: compares a byte read back from the device with the target.
// match: identical. stuck: some bit reads 0 where the target wants 1,
// which programming cannot repair.
// Assumes: purely combinational; the caller decides when to sample.
module eprog_byte_cmp #(
    parameter int DW = 8
) (
    input  logic [DW-1:0] target,
    input  logic [DW-1:0] readback,
    output logic          match,
    output logic          stuck
);

    // Bitwise comparison of target and read-back data.
    always_comb begin
        match = (target == readback);
        stuck = |(target & ~readback);
    end

endmodule

// File: rtl/eprog_sequencer.sv
// Module: pulse-and-verify EPROM programming sequencer (top).
// Walks start_addr..end_addr. For each address it fetches the target
// byte, skips 8'hFF, blank-checks, then repeats setup / pulse / verify
// until the byte matches or MAX_PULSES is reached.
// Assumes: end_addr is reached from start_addr by incrementing; the
// source answers every request eventually; the supply behind vpp_en is
// settled before the first pulse (the first pulse comes after a fetch
// and a read).
module eprog_sequencer #(
    parameter int AW         = 16,
    parameter int DW         = 8,
    parameter int CLK_HZ     = 100_000_000,
    parameter int PULSE_US   = 50,
    parameter int MAX_PULSES = 10,
    parameter int SETUP_CYC  = 2,
    parameter int TDV_CYC    = 3,
    parameter int TOT_W      = 16,
    parameter int PCW        = $clog2(MAX_PULSES + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic [AW-1:0]    start_addr,
    input  logic [AW-1:0]    end_addr,
    output logic             busy,
    output logic             done,
    output logic             fail,
    output logic [AW-1:0]    fail_addr,
    output logic [PCW-1:0]   addr_pulses,
    output logic [TOT_W-1:0] total_pulses,
    output logic             src_req,
    output logic [AW-1:0]    src_addr,
    input  logic             src_valid,
    input  logic [DW-1:0]    src_data,
    output logic [AW-1:0]    rom_addr,
    output logic [DW-1:0]    rom_dout,
    output logic             rom_dout_en,
    input  logic [DW-1:0]    rom_din,
    output logic             rom_ce_pgm_n,
    output logic             rom_oe_n,
    output logic             vpp_en
);
    import eprog_pkg::*;

    localparam int PULSE_CYC = (CLK_HZ / 1000) * PULSE_US / 1000;
    localparam int TCW       = $clog2(PULSE_CYC + SETUP_CYC + TDV_CYC + 1);
    localparam logic [TCW-1:0] LD_PULSE = TCW'(PULSE_CYC - 1);
    localparam logic [TCW-1:0] LD_SETUP = TCW'(SETUP_CYC - 1);
    localparam logic [TCW-1:0] LD_READ  = TCW'(TDV_CYC - 1);
    localparam logic [PCW-1:0] PMAX     = PCW'(MAX_PULSES);

    seq_state_t       state, state_n;
    logic [AW-1:0]    cur_addr;
    logic [DW-1:0]    target;
    logic             fail_q;
    logic [AW-1:0]    fail_addr_q;
    logic [PCW-1:0]   apulse;
    logic [TOT_W-1:0] tpulse;
    logic             tmr_load;
    logic [TCW-1:0]   tmr_val;
    logic             tmr_done;
    logic             rb_match;
    logic             rb_stuck;

    eprog_phase_timer #(.CW(TCW)) u_timer (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (tmr_load),
        .load_val (tmr_val),
        .expired  (tmr_done)
    );

    eprog_byte_cmp #(.DW(DW)) u_cmp (
        .target   (target),
        .readback (rom_din),
        .match    (rb_match),
        .stuck    (rb_stuck)
    );

    // Next phase and timer load on each timed entry.
    always_comb begin
        state_n  = state;
        tmr_load = 1'b0;
        tmr_val  = '0;
        case (state)
            ST_IDLE:   if (start) state_n = ST_FETCH;
            ST_FETCH: begin
                if (src_valid) begin
                    if (src_data == '1) begin
                        state_n = ST_NEXT;
                    end else begin
                        state_n  = ST_BLANK;
                        tmr_load = 1'b1;
                        tmr_val  = LD_READ;
                    end
                end
            end
            ST_BLANK: begin
                if (tmr_done) begin
                    if (rb_stuck)      state_n = ST_FAIL;
                    else if (rb_match) state_n = ST_NEXT;
                    else               state_n = ST_TURN;
                end
            end
            ST_TURN: begin
                state_n  = ST_SETUP;
                tmr_load = 1'b1;
                tmr_val  = LD_SETUP;
            end
            ST_SETUP: begin
                if (tmr_done) begin
                    state_n  = ST_PULSE;
                    tmr_load = 1'b1;
                    tmr_val  = LD_PULSE;
                end
            end
            ST_PULSE:  if (tmr_done) state_n = ST_RECOV;
            ST_RECOV: begin
                state_n  = ST_VERIFY;
                tmr_load = 1'b1;
                tmr_val  = LD_READ;
            end
            ST_VERIFY: begin
                if (tmr_done) begin
                    if (rb_match)            state_n = ST_NEXT;
                    else if (apulse == PMAX) state_n = ST_FAIL;
                    else                     state_n = ST_TURN;
                end
            end
            ST_NEXT:   state_n = (cur_addr == end_addr) ? ST_DONE : ST_FETCH;
            ST_DONE:   state_n = ST_IDLE;
            ST_FAIL:   state_n = ST_IDLE;
            default:   state_n = ST_IDLE;
        endcase
    end

    // Phase register and run bookkeeping registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state       <= ST_IDLE;
            cur_addr    <= '0;
            target      <= '1;
            fail_q      <= 1'b0;
            fail_addr_q <= '0;
            apulse      <= '0;
            tpulse      <= '0;
        end else begin
            state <= state_n;
            case (state)
                ST_IDLE: begin
                    if (start) begin
                        cur_addr <= start_addr;
                        fail_q   <= 1'b0;
                        apulse   <= '0;
                        tpulse   <= '0;
                    end
                end
                ST_FETCH: begin
                    if (src_valid) begin
                        target <= src_data;
                        apulse <= '0;
                    end
                end
                ST_SETUP: begin
                    if (tmr_done) begin
                        apulse <= apulse + 1'b1;
                        tpulse <= tpulse + 1'b1;
                    end
                end
                ST_NEXT: begin
                    if (cur_addr != end_addr) cur_addr <= cur_addr + 1'b1;
                end
                ST_FAIL: begin
                    fail_q      <= 1'b1;
                    fail_addr_q <= cur_addr;
                end
                default: ;
            endcase
        end
    end

    // Port decode from the phase register.
    always_comb begin
        busy         = (state != ST_IDLE);
        vpp_en       = busy;
        done         = (state == ST_DONE);
        fail         = fail_q;
        fail_addr    = fail_addr_q;
        addr_pulses  = apulse;
        total_pulses = tpulse;
        src_req      = (state == ST_FETCH);
        src_addr     = cur_addr;
        rom_addr     = cur_addr;
        rom_dout     = target;
        rom_dout_en  = (state == ST_SETUP) || (state == ST_PULSE);
        rom_oe_n     = !((state == ST_BLANK) || (state == ST_VERIFY));
        rom_ce_pgm_n = !((state == ST_BLANK) || (state == ST_VERIFY) ||
                         (state == ST_PULSE));
    end

endmodule

// File: rtl/eprog_sequencer_chk.sv
// Module: property checker for eprog_sequencer, attached by bind.
// Watches device-side and handshake ports; counts program-pulse cycles
// itself so the pulse-length window needs no deep $past.
// Assumes: the same parameter values as the bound instance.
module eprog_sequencer_chk #(
    parameter int AW         = 16,
    parameter int DW         = 8,
    parameter int CLK_HZ     = 100_000_000,
    parameter int PULSE_US   = 50,
    parameter int MAX_PULSES = 10,
    parameter int PCW        = $clog2(MAX_PULSES + 1)
) (
    input logic           clk,
    input logic           rst_n,
    input logic           busy,
    input logic           done,
    input logic           fail,
    input logic           vpp_en,
    input logic           ce_n,
    input logic           oe_n,
    input logic           dout_en,
    input logic [AW-1:0]  rom_addr,
    input logic [DW-1:0]  rom_dout,
    input logic           src_req,
    input logic           src_valid,
    input logic [AW-1:0]  src_addr,
    input logic [PCW-1:0] addr_pulses
);
    localparam int PULSE_CYC = (CLK_HZ / 1000) * PULSE_US / 1000;
    localparam logic [PCW-1:0] PMAX = PCW'(MAX_PULSES);

    logic [31:0] pgm_run;
    logic        pgm_now;

    assign pgm_now = !ce_n && oe_n;

    // Length so far of the current program pulse.
    always_ff @(posedge clk) begin
        if (!rst_n)       pgm_run <= '0;
        else if (pgm_now) pgm_run <= pgm_run + 1'b1;
        else              pgm_run <= '0;
    end

    a_r1_supply_for_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        pgm_now |-> (vpp_en && dout_en));
    a_r1_supply_idle: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> (!vpp_en && ce_n && oe_n && !dout_en));
    a_r2_pulse_max: assert property (@(posedge clk) disable iff (!rst_n)
        pgm_now |-> (pgm_run < PULSE_CYC));
    a_r2_pulse_len: assert property (@(posedge clk) disable iff (!rst_n)
        (ce_n && pgm_run != 0) |-> (pgm_run == PULSE_CYC));
    a_r2_stable_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        (pgm_now && $past(pgm_now)) |-> ($stable(rom_addr) && $stable(rom_dout)));
    a_r3_read_floats: assert property (@(posedge clk) disable iff (!rst_n)
        !oe_n |-> (!ce_n && !dout_en));
    a_r6_turn_drive: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(dout_en) |-> $past(oe_n));
    a_r6_turn_read: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(oe_n) |-> !$past(dout_en));
    a_r4_limit: assert property (@(posedge clk) disable iff (!rst_n)
        addr_pulses <= PMAX);
    a_r5_fail_idle: assert property (@(posedge clk) disable iff (!rst_n)
        fail |-> !busy);
    a_r10_done_single: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);
    a_r12_req_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (src_req && !src_valid) |=> (src_req && $stable(src_addr)));

endmodule

bind eprog_sequencer eprog_sequencer_chk #(
    .AW(AW), .DW(DW), .CLK_HZ(CLK_HZ), .PULSE_US(PULSE_US),
    .MAX_PULSES(MAX_PULSES), .PCW(PCW)
) u_chk (
    .clk(clk), .rst_n(rst_n), .busy(busy), .done(done), .fail(fail),
    .vpp_en(vpp_en), .ce_n(rom_ce_pgm_n), .oe_n(rom_oe_n),
    .dout_en(rom_dout_en), .rom_addr(rom_addr), .rom_dout(rom_dout),
    .src_req(src_req), .src_valid(src_valid), .src_addr(src_addr),
    .addr_pulses(addr_pulses)
);

// File: tb/eprog_sequencer_bench.sv
// Bench: directed scenarios against a device model in which each
// location needs a set number of pulses, and reads taken before the
// access delay return inverted data.
module eprog_sequencer_bench;
    localparam int AW = 16, DW = 8, CLK_HZ = 1_000_000, PULSE_US = 50;
    localparam int MAXP = 10, SETUP = 2, TDV = 3, TOT_W = 16, PCW = 4;
    localparam int PCYC = 50;

    logic clk = 1'b0, rst_n = 1'b0, start = 1'b0;
    logic [AW-1:0] start_addr = '0, end_addr = '0;
    logic busy, done, fail, src_req, src_valid, rom_dout_en, rom_ce_pgm_n, rom_oe_n, vpp_en;
    logic [AW-1:0] fail_addr, src_addr, rom_addr;
    logic [PCW-1:0] addr_pulses;
    logic [TOT_W-1:0] total_pulses;
    logic [DW-1:0] src_data, rom_dout, rom_din;

    int n_chk = 0, n_bad = 0;
    logic [7:0] mem [16];
    logic [7:0] init_mem [16];
    logic [7:0] tgt_tab [16];
    int need [16];
    int pcnt [16];
    logic load_mem = 1'b0;
    int low_run, rd_run, mon_err, mdl_pulses, fetches;
    logic prev_pgm;
    logic [3:0] pa;
    logic [7:0] pd;

    always #5 clk = ~clk;

    eprog_sequencer #(.AW(AW), .DW(DW), .CLK_HZ(CLK_HZ), .PULSE_US(PULSE_US),
        .MAX_PULSES(MAXP), .SETUP_CYC(SETUP), .TDV_CYC(TDV), .TOT_W(TOT_W), .PCW(PCW))
    u_eprog_sequencer (
        .clk(clk), .rst_n(rst_n), .start(start), .start_addr(start_addr),
        .end_addr(end_addr), .busy(busy), .done(done), .fail(fail),
        .fail_addr(fail_addr), .addr_pulses(addr_pulses), .total_pulses(total_pulses),
        .src_req(src_req), .src_addr(src_addr), .src_valid(src_valid),
        .src_data(src_data), .rom_addr(rom_addr), .rom_dout(rom_dout),
        .rom_dout_en(rom_dout_en), .rom_din(rom_din), .rom_ce_pgm_n(rom_ce_pgm_n),
        .rom_oe_n(rom_oe_n), .vpp_en(vpp_en)
    );

    // Device read path: valid only after TDV cycles of chip enable low (R3).
    assign rom_din = (!rom_ce_pgm_n && !rom_oe_n)
                   ? ((rd_run >= TDV - 1) ? mem[rom_addr[3:0]] : ~mem[rom_addr[3:0]])
                   : 8'h00;

    // Device, source and bus monitor model.
    always @(posedge clk) begin
        if (load_mem) begin
            for (int i = 0; i < 16; i++) begin
                mem[i]  <= init_mem[i];
                pcnt[i] <= 0;
            end
            low_run <= 0; rd_run <= 0; prev_pgm <= 1'b0;
            mdl_pulses <= 0; fetches <= 0; src_valid <= 1'b0; src_data <= 8'h00;
        end else begin
            src_valid <= src_req && !src_valid;
            src_data  <= tgt_tab[src_addr[3:0]];
            if (src_req && src_valid) fetches <= fetches + 1;
            rd_run <= (!rom_ce_pgm_n && !rom_oe_n) ? rd_run + 1 : 0;
            if (rom_dout_en && !rom_oe_n) mon_err <= mon_err + 1;
            if (!rom_ce_pgm_n && rom_oe_n) begin
                low_run <= low_run + 1;
                pa <= rom_addr[3:0];
                pd <= rom_dout;
                if (!vpp_en || !rom_dout_en) mon_err <= mon_err + 1;
            end else begin
                low_run <= 0;
            end
            prev_pgm <= !rom_ce_pgm_n && rom_oe_n;
            if (prev_pgm && rom_ce_pgm_n) begin
                if (low_run != PCYC) mon_err <= mon_err + 1;
                mdl_pulses <= mdl_pulses + 1;
                pcnt[pa] <= pcnt[pa] + 1;
                if (pcnt[pa] + 1 >= need[pa]) mem[pa] <= mem[pa] & pd;
            end
        end
    end

    task automatic chk(input string r, input int act, input int exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", r, act, exp);
        end
    endtask

    task automatic clear_tabs();
        for (int i = 0; i < 16; i++) begin
            init_mem[i] = 8'hFF; tgt_tab[i] = 8'hFF; need[i] = 1;
        end
    endtask

    task automatic load_model();
        @(negedge clk); load_mem = 1'b1;
        @(negedge clk); load_mem = 1'b0;
    endtask

    task automatic run_range(input int a0, input int a1, output int sd, output int sf);
        @(negedge clk);
        start_addr = a0[AW-1:0]; end_addr = a1[AW-1:0]; start = 1'b1;
        @(negedge clk); start = 1'b0;
        sd = 0; sf = 0;
        for (int i = 0; i < 30000 && sd == 0 && sf == 0; i++) begin
            @(negedge clk);
            if (done) sd = 1;
            if (fail) sf = 1;
        end
        if (sd != 0) begin
            @(negedge clk);
            chk("R10 done lasts one cycle", int'(done), 0);
        end
        repeat (2) @(negedge clk);
    endtask

    task automatic t_reset();
        chk("R13 busy", int'(busy), 0);
        chk("R13 done", int'(done), 0);
        chk("R13 fail", int'(fail), 0);
        chk("R13 vpp_en", int'(vpp_en), 0);
        chk("R13 ce_pgm_n", int'(rom_ce_pgm_n), 1);
        chk("R13 oe_n", int'(rom_oe_n), 1);
        chk("R13 dout_en", int'(rom_dout_en), 0);
        chk("R13 counters", int'(addr_pulses) + int'(total_pulses), 0);
    endtask

    task automatic t_basic();
        int sd, sf, e0;
        clear_tabs();
        tgt_tab[0] = 8'hA5; tgt_tab[2] = 8'h3C; tgt_tab[3] = 8'h00;
        load_model(); e0 = mon_err;
        run_range(0, 3, sd, sf);
        chk("R10 done seen", sd, 1);
        chk("R5 no fail", sf, 0);
        chk("R2 byte0", int'(mem[0]), 'hA5);
        chk("R7 FF untouched", int'(mem[1]), 'hFF);
        chk("R2 byte2", int'(mem[2]), 'h3C);
        chk("R2 byte3", int'(mem[3]), 'h00);
        chk("R11 total", int'(total_pulses), 3);
        chk("R11 last addr pulses", int'(addr_pulses), 1);
        chk("R12 fetch per address", fetches, 4);
        chk("R6 R1 monitor clean", mon_err, e0);
        chk("R10 busy low", int'(busy), 0);
    endtask

    task automatic t_multi();
        int sd, sf, e0;
        clear_tabs();
        tgt_tab[4] = 8'h12; need[4] = 4;
        tgt_tab[5] = 8'h80; need[5] = 10;
        load_model(); e0 = mon_err;
        run_range(4, 5, sd, sf);
        chk("R4 done at limit", sd, 1);
        chk("R4 byte4", int'(mem[4]), 'h12);
        chk("R4 byte5", int'(mem[5]), 'h80);
        chk("R11 total", int'(total_pulses), 14);
        chk("R11 addr pulses", int'(addr_pulses), 10);
        chk("R2 model pulses", mdl_pulses, 14);
        chk("R3 monitor clean", mon_err, e0);
    endtask

    task automatic t_limit();
        int sd, sf;
        clear_tabs();
        tgt_tab[6] = 8'h33; need[6] = 11;
        tgt_tab[7] = 8'h44;
        load_model();
        run_range(6, 7, sd, sf);
        chk("R5 fail seen", sf, 1);
        chk("R5 no done", sd, 0);
        chk("R5 fail_addr", int'(fail_addr), 6);
        chk("R4 pulses capped", int'(addr_pulses), 10);
        chk("R11 total", int'(total_pulses), 10);
        chk("R5 stopped, next untouched", int'(mem[7]), 'hFF);
        chk("R5 busy low", int'(busy), 0);
        chk("R5 fail held", int'(fail), 1);
    endtask

    task automatic t_blank();
        int sd, sf;
        clear_tabs();
        tgt_tab[8] = 8'h11;
        tgt_tab[9] = 8'hF0; init_mem[9] = 8'h0F;
        load_model();
        run_range(8, 9, sd, sf);
        chk("R8 fail seen", sf, 1);
        chk("R8 fail_addr", int'(fail_addr), 9);
        chk("R8 no pulse at stuck byte", int'(addr_pulses), 0);
        chk("R8 total", int'(total_pulses), 1);
        chk("R8 stuck byte unchanged", int'(mem[9]), 'h0F);
    endtask

    task automatic t_skip();
        int sd, sf, e0;
        clear_tabs();
        tgt_tab[10] = 8'h42; init_mem[10] = 8'h42;
        init_mem[12] = 8'h00;
        load_model(); e0 = mon_err;
        run_range(10, 12, sd, sf);
        chk("R9 done", sd, 1);
        chk("R9 fail cleared by start", int'(fail), 0);
        chk("R9 no pulses", mdl_pulses, 0);
        chk("R7 total zero", int'(total_pulses), 0);
        chk("R7 FF target leaves stored 00", int'(mem[12]), 'h00);
        chk("R12 fetches", fetches, 3);
        chk("R6 monitor clean", mon_err, e0);
    endtask

    initial begin
        mon_err = 0;
        repeat (3) @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_basic();
        t_multi();
        t_limit();
        t_blank();
        t_skip();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (190000) @(posedge clk);
        n_chk++; n_bad++;
        $display("FAIL watchdog: run hung actual=1 expected=0");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

endmodule